// File: doc/BRIEF.md
# Modem Control and Diagnostic Loopback Unit

This block holds the modem-control register of one serial channel and steers the channel's serial and modem signals. In normal operation each control bit drives an active-low modem output pin with inversion. The modem input pins pass through a two-stage synchronizer and become active-high status bits. The serial transmit and receive lines pass straight between the pins and the channel's transmitter and receiver.

Setting the loopback bit isolates the channel from its pins. The transmitter output is routed into the receiver input, and the external serial line idles at mark. The external modem outputs go inactive (high). The four low control bits then take the place of the modem inputs as the status sources, so software can exercise the modem-status interrupt path by writing the register.

A change detector records a delta flag for each status bit. It sets the flag on any change for the clear-to-send, data-set-ready and carrier-detect bits, and on the trailing edge for ring indicate. A status-read strobe clears all the flags. The block raises one combined request while any flag is set.

Top module: `mdm_loop_unit`

## Requirements
- R1: After reset the register reads 0x00, all four modem outputs are high, the serial pin follows the transmitter, and the status, delta and request outputs are all 0.
- R2: A write stores data bits 4..0; a read returns them in bits 4..0, and bits 7..5 always read 0 whatever was written.
- R3: Outside loopback, control bit 0 drives `dtr_n_o`, bit 1 drives `rts_n_o`, bit 2 drives `op1_n_o` and bit 3 drives `op2_n_o`, each inverted (a 1 in the register gives a low pin).
- R4: Outside loopback (bit 4 = 0), `tx_pin_o` equals `tx_core_i` and `rx_core_o` equals `rx_pin_i`.
- R5: Outside loopback, `mdm_sts_o` is the inverse of the input pins in the order [0]=CTS, [1]=DSR, [2]=RI, [3]=CD. A pin change reaches the status on the third rising clock edge after it.
- R6: In loopback (bit 4 = 1), `tx_pin_o` is held at 1, `rx_core_o` equals `tx_core_i`, and `rx_pin_i` has no effect.
- R7: In loopback, all four modem output pins are held high, whatever the value of bits 3..0.
- R8: In loopback, the status becomes CTS = bit 1, DSR = bit 0, RI = bit 2 and CD = bit 3, two edges after the write, and the modem input pins have no effect.
- R9: Delta flags [0] (CTS), [1] (DSR) and [3] (CD) are set whenever the matching status bit changes in either direction.
- R10: Delta flag [2] (RI) is set only when the RI status falls from 1 to 0; a rise leaves it unchanged.
- R11: A high `sts_rd_i` clears every delta flag at the next edge. A change that is detected at that same edge still sets its flag.
- R12: `mdm_irq_o` is high exactly when at least one delta flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| sts_rd_i | input | 1 | Status-read strobe, clears delta flags |
| tx_core_i | input | 1 | Serial output of the channel transmitter |
| rx_core_o | output | 1 | Serial input to the channel receiver |
| tx_pin_o | output | 1 | External serial output pin |
| rx_pin_i | input | 1 | External serial input pin |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| cd_n_i | input | 1 | Carrier-detect pin, active low |
| ri_n_i | input | 1 | Ring-indicate pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| dtr_n_o | output | 1 | Data-terminal-ready pin, active low |
| op1_n_o | output | 1 | General output 1, active low |
| op2_n_o | output | 1 | General output 2, active low |
| mdm_sts_o | output | 4 | Modem status {CD, RI, DSR, CTS} |
| mdm_dlt_o | output | 4 | Delta flags {CD, RI, DSR, CTS} |
| mdm_irq_o | output | 1 | Combined modem-status request |

## Verification
All 256 register values are written in sequence under four fixed input-pin patterns (all high, all low, and two alternating). Each write is compared with an arithmetic model of the read-back, the output pins, the status and the accumulated deltas. Consecutive values toggle single control bits in both directions, so both edge polarities occur on every status bit. This separates any-edge detection from RI trailing-edge detection, and pin-driven from register-driven status. Changing the pins while loopback is on shows that the pins are isolated. A single pin step measures the synchronizer latency, the serial path is tried with all four tx/rx combinations in each mode, and one cycle applies a clear and a new change together.

// File: rtl/mdm_loop_pkg.sv
`timescale 1ns/1ps
package mdm_loop_pkg;
    localparam int MDM_N  = 4;
    localparam int CTS_IX = 0;
    localparam int DSR_IX = 1;
    localparam int RI_IX  = 2;
    localparam int CD_IX  = 3;

    // Field order matches the register bit order 4..0
    typedef struct packed {
        logic loop;
        logic op2;
        logic op1;
        logic rts;
        logic dtr;
    } mdm_ctrl_t;

    typedef struct packed {
        logic [MDM_N-1:0] sts;
        logic [MDM_N-1:0] dlt;
    } mdm_state_t;
endpackage

// File: rtl/mdm_sync.sv
`timescale 1ns/1ps
module mdm_sync #(
    parameter int   W       = 4,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= {W{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/mdm_ctrl_reg.sv
`timescale 1ns/1ps
module mdm_ctrl_reg
    import mdm_loop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output mdm_ctrl_t         ctrl
);
    localparam int CTRL_W = $bits(mdm_ctrl_t);

    mdm_ctrl_t ctrl_d, ctrl_q;
    logic      unused_rsvd;

    assign unused_rsvd = ^wr_data[DATA_W-1:CTRL_W];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) ctrl_d = mdm_ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl    = ctrl_q;
    assign rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == $past(wr_data[CTRL_W-1:0])));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/mdm_delta.sv
`timescale 1ns/1ps
module mdm_delta
    import mdm_loop_pkg::*;
#(
    parameter int TRAIL_IX = RI_IX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MDM_N-1:0] src,
    input  logic             clr,
    output logic [MDM_N-1:0] sts,
    output logic [MDM_N-1:0] dlt,
    output logic             irq
);
    mdm_state_t       st_d, st_q;
    logic [MDM_N-1:0] chg;

    for (genvar g = 0; g < MDM_N; g++) begin : g_edge
        if (g == TRAIL_IX) begin : g_trail
            assign chg[g] = st_q.sts[g] & ~src[g];
        end else begin : g_any
            assign chg[g] = st_q.sts[g] ^ src[g];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.sts = src;
        st_d.dlt = (clr ? '0 : st_q.dlt) | chg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts = st_q.sts;
    assign dlt = st_q.dlt;
    assign irq = |st_q.dlt;

    // R9
    cts_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts[CTS_IX] != $past(st_q.sts[CTS_IX])) |-> st_q.dlt[CTS_IX]);
    // R9
    cd_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts[CD_IX] != $past(st_q.sts[CD_IX])) |-> st_q.dlt[CD_IX]);
    // R10
    ri_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.sts[TRAIL_IX]) |-> st_q.dlt[TRAIL_IX]);
    // R10
    ri_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.sts[TRAIL_IX]) && $past(clr)) |-> !st_q.dlt[TRAIL_IX]);
    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (src == st_q.sts)) |=> (st_q.dlt == '0));
endmodule

// File: rtl/mdm_loop_unit.sv
`timescale 1ns/1ps
module mdm_loop_unit
    import mdm_loop_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              sts_rd_i,
    input  logic              tx_core_i,
    output logic              rx_core_o,
    output logic              tx_pin_o,
    input  logic              rx_pin_i,
    input  logic              cts_n_i,
    input  logic              dsr_n_i,
    input  logic              cd_n_i,
    input  logic              ri_n_i,
    output logic              rts_n_o,
    output logic              dtr_n_o,
    output logic              op1_n_o,
    output logic              op2_n_o,
    output logic [MDM_N-1:0]  mdm_sts_o,
    output logic [MDM_N-1:0]  mdm_dlt_o,
    output logic              mdm_irq_o
);
    mdm_ctrl_t        ctrl;
    logic [MDM_N-1:0] pin_raw, pin_s, lb_src, sel_src;

    mdm_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_i),
        .wr_data (reg_wdata_i),
        .rd_data (reg_rdata_o),
        .ctrl    (ctrl)
    );

    assign pin_raw = {cd_n_i, ri_n_i, dsr_n_i, cts_n_i};

    mdm_sync #(.W(MDM_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_raw),
        .dout  (pin_s)
    );

    always_comb begin
        lb_src         = '0;
        lb_src[CTS_IX] = ctrl.rts;
        lb_src[DSR_IX] = ctrl.dtr;
        lb_src[RI_IX]  = ctrl.op1;
        lb_src[CD_IX]  = ctrl.op2;
        sel_src        = ctrl.loop ? lb_src : ~pin_s;
    end

    mdm_delta #(.TRAIL_IX(RI_IX)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (sel_src),
        .clr   (sts_rd_i),
        .sts   (mdm_sts_o),
        .dlt   (mdm_dlt_o),
        .irq   (mdm_irq_o)
    );

    always_comb begin
        tx_pin_o  = ctrl.loop ? 1'b1 : tx_core_i;
        rx_core_o = ctrl.loop ? tx_core_i : rx_pin_i;
        rts_n_o   = ctrl.loop | ~ctrl.rts;
        dtr_n_o   = ctrl.loop | ~ctrl.dtr;
        op1_n_o   = ctrl.loop | ~ctrl.op1;
        op2_n_o   = ctrl.loop | ~ctrl.op2;
    end

    // R6
    loop_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[4] |-> (tx_pin_o && (rx_core_o == tx_core_i)));
    // R7
    loop_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[4] |-> (rts_n_o && dtr_n_o && op1_n_o && op2_n_o));
    // R8
    loop_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata_o[4] |=> (mdm_sts_o == {$past(reg_rdata_o[3]), $past(reg_rdata_o[2]),
                                          $past(reg_rdata_o[0]), $past(reg_rdata_o[1])}));
    // R12
    irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdm_irq_o == (mdm_dlt_o != '0));
endmodule

// File: tb/mdm_loop_unit_test.sv
`timescale 1ns/1ps
module mdm_loop_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sts_rd = 1'b0;
    logic       tx_core = 1'b1, rx_core, tx_pin, rx_pin = 1'b1;
    logic [3:0] pins = 4'hF;   // {cd_n, ri_n, dsr_n, cts_n}
    logic       rts_n, dtr_n, op1_n, op2_n;
    logic [3:0] sts, dlt;
    logic       irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_ctrl = '0;
    logic [3:0] m_sts  = '0;
    logic [3:0] m_dlt  = '0;

    always #2.5 clk = ~clk;

    mdm_loop_unit uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .sts_rd_i(sts_rd),
        .tx_core_i(tx_core), .rx_core_o(rx_core), .tx_pin_o(tx_pin), .rx_pin_i(rx_pin),
        .cts_n_i(pins[0]), .dsr_n_i(pins[1]), .cd_n_i(pins[3]), .ri_n_i(pins[2]),
        .rts_n_o(rts_n), .dtr_n_o(dtr_n), .op1_n_o(op1_n), .op2_n_o(op2_n),
        .mdm_sts_o(sts), .mdm_dlt_o(dlt), .mdm_irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] f_sts(input logic [7:0] c, input logic [3:0] p);
        return c[4] ? {c[3], c[2], c[0], c[1]} : ~p;
    endfunction

    task automatic model_upd();
        logic [3:0] n;
        n = f_sts(m_ctrl, pins);
        m_dlt = m_dlt | ((m_sts ^ n) & 4'b1011) | ((m_sts[2] & ~n[2]) ? 4'b0100 : 4'b0000);
        m_sts = n;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        m_ctrl = v;
    endtask

    task automatic clear_dlt();
        @(negedge clk); sts_rd = 1'b1;
        @(negedge clk); sts_rd = 1'b0;
        m_dlt = '0;
        chk("R11 delta after clear", {4'h0, dlt}, 8'h00);
        chk("R12 irq after clear", {7'h0, irq}, 8'h00);
    endtask

    task automatic check_all();
        logic [3:0] exp_pins;
        exp_pins = m_ctrl[4] ? 4'hF : ~m_ctrl[3:0];
        chk("R2 readback", reg_rdata, m_ctrl & 8'h1F);
        chk(m_ctrl[4] ? "R7 pins" : "R3 pins", {4'h0, op2_n, op1_n, rts_n, dtr_n}, {4'h0, exp_pins});
        chk(m_ctrl[4] ? "R8 status" : "R5 status", {4'h0, sts}, {4'h0, m_sts});
        chk("R9 R10 deltas", {4'h0, dlt}, {4'h0, m_dlt});
        chk("R12 irq", {7'h0, irq}, {7'h0, (m_dlt != 4'h0)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] pats [4];
        pats[0] = 4'hF; pats[1] = 4'h0; pats[2] = 4'h5; pats[3] = 4'hA;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 readback", reg_rdata, 8'h00);
        chk("R1 pins", {4'h0, op2_n, op1_n, rts_n, dtr_n}, 8'h0F);
        chk("R1 tx path", {7'h0, tx_pin}, {7'h0, tx_core});
        chk("R1 status", {4'h0, sts}, 8'h00);
        chk("R1 deltas", {4'h0, dlt}, 8'h00);
        chk("R1 irq", {7'h0, irq}, 8'h00);

        // R4 normal serial path
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            tx_core = t[0]; rx_pin = t[1];
            #1;
            chk("R4 tx pin", {7'h0, tx_pin}, {7'h0, t[0]});
            chk("R4 rx core", {7'h0, rx_core}, {7'h0, t[1]});
        end

        // R5 synchronizer latency: CTS pin falls
        @(negedge clk);
        pins = 4'hE;
        @(negedge clk); @(negedge clk);
        chk("R5 status before third edge", {4'h0, sts}, 8'h00);
        @(negedge clk);
        chk("R5 status at third edge", {4'h0, sts}, 8'h01);
        model_upd();
        check_all();
        clear_dlt();

        // Sweep of all register values under several pin patterns
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            pins = pats[p];
            repeat (4) @(negedge clk);
            model_upd();
            check_all();
            for (int v = 0; v < 256; v++) begin
                wr(v[7:0]);
                repeat (3) @(negedge clk);
                model_upd();
                check_all();
                if ((v % 8) == 7) clear_dlt();
            end
        end

        // R6 loopback serial path, rx pin ignored
        wr(8'h10);
        repeat (3) @(negedge clk);
        model_upd();
        clear_dlt();
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            tx_core = t[0]; rx_pin = t[1];
            #1;
            chk("R6 tx pin idle", {7'h0, tx_pin}, 8'h01);
            chk("R6 rx core from tx", {7'h0, rx_core}, {7'h0, t[0]});
        end

        // R11 clear and new change at the same edge
        wr(8'h11);
        repeat (3) @(negedge clk);
        model_upd();
        chk("R11 prior DSR delta", {4'h0, dlt}, 8'h02);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = 8'h13;
        @(negedge clk);
        reg_wr = 1'b0; sts_rd = 1'b1;
        @(negedge clk);
        sts_rd = 1'b0;
        chk("R11 change wins over clear", {4'h0, dlt}, 8'h01);
        chk("R12 irq after clear with change", {7'h0, irq}, 8'h01);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule